// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from an inbound byte stream into system memory through a ring of four-word receive descriptors. For each frame it reads the current descriptor to learn whether hardware owns it, how large its buffer is, where the buffer sits and whether the descriptor closes the ring. It then writes the frame bytes into that buffer one byte lane at a time. Finally it writes back the descriptor's first word with the segment length, status flags and the owner bit cleared, which hands the descriptor to software.

Frames larger than one buffer continue into following descriptors. The first descriptor carries a first-segment flag and the final one a last-segment flag. The stream supplies start and end markers, a 5-bit error code and multicast/broadcast indications, so filtering and CRC checking happen upstream. Software sets the ring base, two enables and two length-policy bits, and gets one-cycle event pulses. Descriptors are 16-byte aligned. Receive buffers must start at an address that is 2 modulo 4 and must be at least 64 bytes long.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the block issues no memory request and raises no event pulse, and the first descriptor used is the one at the ring base.
- R2: A frame that starts while receive-enable or receive-DMA-enable is low is consumed from the stream and discarded, with no memory write and no event pulse.
- R3: If the descriptor word 0 read at frame start has bit 31 (owner) clear, the frame is discarded, the descriptor is left untouched, and the no-buffer and lost-frame pulses fire in the same cycle.
- R4: If the descriptor's buffer address (word 2) does not have bits 1:0 equal to 2'b10, or its buffer size (word 1 bits 10:0) is zero, the frame is discarded with a lost-frame pulse only. The descriptor stays untouched and remains the current one.
- R5: Byte i of a segment is written to buffer address + i as a single-lane write (one-hot byte enable, byte replicated on all lanes), in stream order.
- R6: Status write-back is one full-word write to word 0 with bit 31 clear, bits 10:0 segment length, bit 16 multicast, bit 17 broadcast, bits 22:18 error code, bit 28 last segment and bit 29 first segment. It occurs after all data writes of that segment.
- R7: The error code written is the OR of the stream error code over all beats so far. Multicast and broadcast are taken from the frame's first beat.
- R8: When a segment reaches the buffer size before frame end, the descriptor is closed with the last-segment flag clear, and the frame continues in the next descriptor with the first-segment flag clear.
- R9: A descriptor whose word 1 bit 31 is set is followed by the descriptor at the ring base. Otherwise the next descriptor is 16 bytes further on.
- R10: A frame shorter than 64 bytes is dropped silently, with its descriptor left hardware-owned and current, unless the keep-short bit is set. In that case it is stored normally.
- R11: With keep-long clear, a frame longer than 1518 bytes is cut at 1518 stored bytes and its last descriptor gets error code bit 0 set. With keep-long set it is stored whole.
- R12: The frame-done pulse is one cycle wide and follows the status write of the last segment.
- R13: A memory request holds its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | 32 | Byte address of descriptor 0 (16-byte aligned) |
| rx_en | input | 1 | Receive enable; low while idle also rewinds to the ring base |
| rx_dma_en | input | 1 | Receive DMA enable |
| keep_short | input | 1 | Store frames under 64 bytes |
| keep_long | input | 1 | Store frames over 1518 bytes whole |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat accepted when high with in_valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | First beat of a frame |
| in_eof | input | 1 | Last beat of a frame |
| in_err | input | 5 | Error code of the beat |
| in_mcast | input | 1 | Multicast indication (first beat) |
| in_bcast | input | 1 | Broadcast indication (first beat) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| irq_rx_done | output | 1 | Frame stored pulse |
| irq_no_buf | output | 1 | No hardware-owned descriptor pulse |
| irq_lost | output | 1 | Frame lost pulse |

## Verification
The store path is exercised with frames that fit one buffer, frames that split across a descriptor carrying the end-of-ring flag, and frames of exactly 64, 10 and 1530 bytes. These cases separate normal write-back from segmentation, wrap, the short-frame policy and the long-frame policy. Rejection paths use a software-owned descriptor, a 4-byte-aligned buffer and disabled DMA. Together they distinguish the no-buffer event from the lost-only event and from silent discard, and each is followed by a good frame to show which descriptor stayed current. Memory acknowledges are stalled pseudo-randomly throughout, so data placement is checked under back-pressure.

// File: rtl/rxd_pkg.sv
// Shared definitions for the receive descriptor ring writer.
// Assumes a 32-bit descriptor word layout decoded by driver software.
package rxd_pkg;
    localparam int LEN_W      = 11;
    localparam int ERR_W      = 5;
    localparam int OWN_BIT    = 31;
    localparam int RING_END   = 31;
    localparam int FIRST_BIT  = 29;
    localparam int LAST_BIT   = 28;
    localparam int ERR_LSB    = 18;
    localparam int BCAST_BIT  = 17;
    localparam int MCAST_BIT  = 16;

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_RD1, S_RD2, S_DATA, S_WRITE, S_CLOSE, S_DROP
    } rxd_state_t;

    // Builds the word-0 status handed back to software (owner cleared).
    function automatic logic [31:0] mk_status(
        input logic [LEN_W-1:0] len,
        input logic [ERR_W-1:0] err,
        input logic             mc,
        input logic             bc,
        input logic             fs,
        input logic             ls
    );
        logic [31:0] w;
        w = '0;
        w[LEN_W-1:0]              = len;
        w[MCAST_BIT]              = mc;
        w[BCAST_BIT]              = bc;
        w[ERR_LSB +: ERR_W]       = err;
        w[LAST_BIT]               = ls;
        w[FIRST_BIT]              = fs;
        w[OWN_BIT]                = 1'b0;
        return w;
    endfunction
endpackage

// File: rtl/rxd_ring_ptr.sv
// Current-descriptor pointer for the receive ring.
// Follows ring_base until the first advance; wraps to ring_base on an
// end-of-ring descriptor. Assumes ring_base is stable while receiving.
module rxd_ring_ptr #(
    parameter int AW     = 32,
    parameter int STRIDE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    input  logic          wrap,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] cur
);
    logic          held;
    logic [AW-1:0] ptr;

    assign cur = held ? ptr : base;

    // Step to the next descriptor or fall back to the ring base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            ptr  <= '0;
        end else if (restart) begin
            held <= 1'b0;
        end else if (advance) begin
            held <= 1'b1;
            ptr  <= wrap ? base : cur + AW'(STRIDE);
        end
    end
endmodule

// File: rtl/rxd_count.sv
// Byte counters for the frame in progress: bytes in the current segment
// and bytes stored for the whole frame. Assumes clears and increments
// never coincide for the same counter.
module rxd_count #(
    parameter int LEN_W = 11,
    parameter int TOT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clr,
    input  logic             seg_clr,
    input  logic             inc,
    output logic [LEN_W-1:0] seg_cnt,
    output logic [TOT_W-1:0] tot_cnt
);
    // Segment byte count, restarted for each fetched buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                    seg_cnt <= '0;
        else if (frame_clr || seg_clr) seg_cnt <= '0;
        else if (inc)                  seg_cnt <= seg_cnt + 1'b1;
    end

    // Frame byte count, restarted at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)         tot_cnt <= '0;
        else if (frame_clr) tot_cnt <= '0;
        else if (inc)       tot_cnt <= tot_cnt + 1'b1;
    end
endmodule

// File: rtl/rx_ring_writer.sv
// Receive descriptor ring writer.
// Fetches the current descriptor when a frame starts, stores the frame
// byte by byte into the buffer, and writes word 0 back with owner cleared.
// Assumes: descriptors 16-byte aligned, buffers at 2 mod 4 and at least
// MIN_FRAME bytes, memory read data valid in the acknowledge cycle.
module rx_ring_writer
    import rxd_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DESC_B    = 16,
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1518
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          rx_en,
    input  logic          rx_dma_en,
    input  logic          keep_short,
    input  logic          keep_long,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic [4:0]    in_err,
    input  logic          in_mcast,
    input  logic          in_bcast,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          irq_rx_done,
    output logic          irq_no_buf,
    output logic          irq_lost
);
    localparam int TOT_W = LEN_W + 1;

    rxd_state_t        state, nxt;
    logic [AW-1:0]     cur_desc, buf_addr, data_addr;
    logic [LEN_W-1:0]  bufsz, seg_cnt;
    logic [TOT_W-1:0]  tot_cnt;
    logic              end_flag, first_seg, eof_q, mc_q, bc_q, trunc;
    logic [7:0]        byte_q;
    logic [ERR_W-1:0]  err_acc;
    logic              fr_clr, sg_clr, inc, adv;
    logic              f_done, f_nobuf, f_lost;
    logic              enabled, at_max, runt, seg_full, bad_buf, accept;

    assign enabled   = rx_en && rx_dma_en;
    assign at_max    = (int'(tot_cnt) >= MAX_FRAME) && !keep_long;
    assign runt      = (int'(tot_cnt) + 1 < MIN_FRAME) && !keep_short;
    assign seg_full  = (seg_cnt + 1'b1) == bufsz;
    assign bad_buf   = (mem_rdata[1:0] != 2'b10) || (bufsz == '0);
    assign data_addr = buf_addr + AW'(seg_cnt);
    assign accept    = (state == S_DATA) && in_valid;

    rxd_ring_ptr #(.AW(AW), .STRIDE(DESC_B)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state == S_IDLE && !rx_en),
        .advance (adv),
        .wrap    (end_flag),
        .base    (ring_base),
        .cur     (cur_desc)
    );

    rxd_count #(.LEN_W(LEN_W), .TOT_W(TOT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_clr (fr_clr),
        .seg_clr   (sg_clr),
        .inc       (inc),
        .seg_cnt   (seg_cnt),
        .tot_cnt   (tot_cnt)
    );

    // Stream acceptance: stray beats drained while idle, frame beats taken in data/drop.
    always_comb begin
        unique case (state)
            S_IDLE:         in_ready = !in_sof;
            S_DATA, S_DROP: in_ready = 1'b1;
            default:        in_ready = 1'b0;
        endcase
    end

    // Memory request generation for descriptor reads, data bytes and status.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_desc;
        mem_wdata = '0;
        mem_be    = 4'hf;
        unique case (state)
            S_RD0: mem_req = 1'b1;
            S_RD1: begin mem_req = 1'b1; mem_addr = cur_desc + AW'(4); end
            S_RD2: begin mem_req = 1'b1; mem_addr = cur_desc + AW'(8); end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = data_addr;
                mem_wdata = {4{byte_q}};
                mem_be    = 4'b0001 << data_addr[1:0];
            end
            S_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = mk_status(seg_cnt, err_acc | {{(ERR_W-1){1'b0}}, trunc},
                                      mc_q, bc_q, first_seg, eof_q);
            end
            default: ;
        endcase
    end

    // Next-state decisions and one-cycle control strobes.
    always_comb begin
        nxt = state; fr_clr = 1'b0; sg_clr = 1'b0; inc = 1'b0; adv = 1'b0;
        f_done = 1'b0; f_nobuf = 1'b0; f_lost = 1'b0;
        unique case (state)
            S_IDLE: if (in_valid && in_sof) begin
                nxt    = enabled ? S_RD0 : S_DROP;
                fr_clr = enabled;
            end
            S_RD0: if (mem_ack) begin
                if (!mem_rdata[OWN_BIT]) begin
                    f_nobuf = 1'b1; f_lost = 1'b1; nxt = S_DROP;
                end else nxt = S_RD1;
            end
            S_RD1: if (mem_ack) nxt = S_RD2;
            S_RD2: if (mem_ack) begin
                if (bad_buf) begin f_lost = 1'b1; nxt = S_DROP; end
                else begin sg_clr = 1'b1; nxt = S_DATA; end
            end
            S_DATA: if (in_valid) begin
                if (trunc || at_max) nxt = in_eof ? S_CLOSE : S_DATA;
                else                 nxt = S_WRITE;
            end
            S_WRITE: if (mem_ack) begin
                inc = 1'b1;
                if (eof_q)         nxt = runt ? S_IDLE : S_CLOSE;
                else if (seg_full) nxt = S_CLOSE;
                else               nxt = S_DATA;
            end
            S_CLOSE: if (mem_ack) begin
                adv = 1'b1;
                if (eof_q) begin f_done = 1'b1; nxt = S_IDLE; end
                else nxt = S_RD0;
            end
            S_DROP: if (in_valid && in_eof) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Descriptor fields captured from the word-1 and word-2 reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bufsz <= '0; end_flag <= 1'b0; buf_addr <= '0;
        end else if (mem_ack && state == S_RD1) begin
            bufsz    <= mem_rdata[LEN_W-1:0];
            end_flag <= mem_rdata[RING_END];
        end else if (mem_ack && state == S_RD2) begin
            buf_addr <= mem_rdata;
        end
    end

    // Per-frame status: segment order, error accumulation, flags, truncation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_seg <= 1'b0; err_acc <= '0; mc_q <= 1'b0; bc_q <= 1'b0;
            trunc <= 1'b0; eof_q <= 1'b0; byte_q <= '0;
        end else if (fr_clr) begin
            first_seg <= 1'b1; err_acc <= '0; trunc <= 1'b0; eof_q <= 1'b0;
        end else if (accept) begin
            byte_q  <= in_data;
            eof_q   <= in_eof;
            err_acc <= err_acc | in_err;
            if (in_sof) begin mc_q <= in_mcast; bc_q <= in_bcast; end
            if (at_max) trunc <= 1'b1;
        end else if (mem_ack && state == S_CLOSE && !eof_q) begin
            first_seg <= 1'b0;
        end
    end

    // Registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rx_done <= 1'b0; irq_no_buf <= 1'b0; irq_lost <= 1'b0;
        end else begin
            irq_rx_done <= f_done; irq_no_buf <= f_nobuf; irq_lost <= f_lost;
        end
    end
endmodule

// File: rtl/rx_ring_writer_chk.sv
// Protocol checker for rx_ring_writer, attached through bind.
// Observes ports only; assumes nothing about internal state.
module rx_ring_writer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [3:0]  mem_be,
    input logic        mem_ack,
    input logic        irq_rx_done,
    input logic        irq_no_buf,
    input logic        irq_lost
);
    // R13: an unacknowledged request is held unchanged.
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R3: a no-buffer event is always also a lost frame.
    assert_nobuf_lost_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_no_buf |-> irq_lost);

    // R12: frame-done is a single-cycle pulse after an accepted status write.
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_done |=> !irq_rx_done);
    assert_done_after_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_done |-> $past(mem_req && mem_we && mem_ack && mem_be == 4'hf));

    // R6: every full-word write is a status hand-back with owner clear.
    assert_status_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_be == 4'hf |-> !mem_wdata[31] && mem_addr[3:0] == 4'h0);

    // R5: data writes use one lane with the byte replicated.
    assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_be != 4'hf |-> $onehot(mem_be) && mem_wdata[7:0] == mem_wdata[31:24]);
endmodule

bind rx_ring_writer rx_ring_writer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .irq_rx_done(irq_rx_done), .irq_no_buf(irq_no_buf),
    .irq_lost(irq_lost)
);

// File: tb/rx_ring_writer_test.sv
// Directed bench for rx_ring_writer with a stalling memory model.
module rx_ring_writer_test;
    localparam logic [31:0] BASE = 32'h100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_en = 1'b1, rx_dma_en = 1'b1, keep_short = 1'b0, keep_long = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_mcast = 1'b0, in_bcast = 1'b0;
    logic [7:0] in_data = '0;
    logic [4:0] in_err = '0;
    logic in_ready, mem_req, mem_we, mem_ack, irq_rx_done, irq_no_buf, irq_lost;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0] mem_be;
    logic [31:0] mem [0:1023];
    logic [4:0] lfsr = 5'h15;
    int total = 0, bad = 0, n_done = 0, n_nobuf = 0, n_lost = 0, n_wr = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rx_ring_writer uut (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE), .rx_en(rx_en), .rx_dma_en(rx_dma_en),
        .keep_short(keep_short), .keep_long(keep_long), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
        .in_mcast(in_mcast), .in_bcast(in_bcast), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .irq_rx_done(irq_rx_done), .irq_no_buf(irq_no_buf),
        .irq_lost(irq_lost)
    );

    // Memory model with pseudo-random acknowledge stalls (exercises R13).
    assign mem_ack   = mem_req && !(lfsr[0] && lfsr[3]);
    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) begin
        lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
        if (mem_req && mem_ack && mem_we) begin
            n_wr <= n_wr + 1;
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mem[mem_addr[11:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
        end
        if (rst_n) begin
            if (irq_rx_done) n_done  <= n_done + 1;
            if (irq_no_buf)  n_nobuf <= n_nobuf + 1;
            if (irq_lost)    n_lost  <= n_lost + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_byte(input int a);
        return mem[a[11:2]][8*a[1:0] +: 8];
    endfunction

    function automatic logic [31:0] dw0(input int idx);
        return mem[(BASE + 32'(idx) * 16) >> 2];
    endfunction

    task automatic set_desc(input int idx, input int sz, input logic [31:0] ba, input bit endf);
        int w;
        w = (BASE + idx * 16) >> 2;
        mem[w]     = 32'h8000_0000;
        mem[w + 1] = {endf, 20'b0, 11'(sz)};
        mem[w + 2] = ba;
    endtask

    task automatic push(input logic [7:0] d, input bit s, input bit e, input logic [4:0] er,
                        input bit mc, input bit bc);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_err = er;
        in_mcast = mc; in_bcast = bc;
        #1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = '0;
    endtask

    task automatic send(input int len, input logic [7:0] seed, input logic [4:0] er,
                        input bit mc, input bit bc);
        for (int i = 0; i < len; i++)
            push(8'(seed + i), i == 0, i == len - 1, (i == len - 1) ? er : 5'd0, mc, bc);
        repeat (40) @(negedge clk);
    endtask

    task automatic chk_buf(input string req, input int a, input int off, input int len,
                           input logic [7:0] seed);
        int mis;
        mis = 0;
        for (int i = 0; i < len; i++)
            if (rd_byte(a + i) !== 8'(seed + off + i)) mis++;
        chk(req, mis, 0);
    endtask

    task automatic t_reset;
        chk("R1 mem_req", {31'b0, mem_req}, 0);
        chk("R1 irqs", {29'b0, irq_rx_done, irq_no_buf, irq_lost}, 0);
    endtask

    task automatic t_basic;
        int d;
        d = n_done;
        send(70, 8'h10, 5'd0, 1'b1, 1'b0);
        chk("R6 R9 status d0", dw0(0), 32'h3001_0046);
        chk_buf("R5 R13 data d0", 32'h182, 0, 70, 8'h10);
        chk("R12 done count", n_done - d, 1);
    endtask

    task automatic t_disabled;
        int w, d;
        w = n_wr; d = n_done;
        rx_dma_en = 1'b0;
        send(70, 8'h20, 5'd0, 1'b0, 1'b0);
        rx_dma_en = 1'b1;
        chk("R2 no writes", n_wr - w, 0);
        chk("R2 no pulse", n_done - d + n_lost, 0);
        chk("R2 d1 untouched", dw0(1), 32'h8000_0000);
    endtask

    task automatic t_error_flags;
        send(64, 8'h30, 5'd4, 1'b0, 1'b1);
        chk("R7 status d1", dw0(1), 32'h3012_0040);
        chk_buf("R5 data d1", 32'h202, 0, 64, 8'h30);
    endtask

    task automatic t_runt;
        int d;
        d = n_done;
        send(10, 8'h50, 5'd0, 1'b0, 1'b0);
        chk("R10 runt dropped", dw0(2), 32'h8000_0000);
        chk("R10 no pulse", n_done - d, 0);
        keep_short = 1'b1;
        send(10, 8'h58, 5'd0, 1'b0, 1'b0);
        keep_short = 1'b0;
        chk("R10 runt kept", dw0(2), 32'h3000_000A);
        chk_buf("R10 runt data", 32'h282, 0, 10, 8'h58);
    endtask

    task automatic t_multi_wrap;
        int d;
        d = n_done;
        set_desc(3, 64, 32'h302, 1'b1);
        set_desc(0, 64, 32'h182, 1'b0);
        send(100, 8'h40, 5'd0, 1'b0, 1'b0);
        chk("R8 first segment", dw0(3), 32'h2000_0040);
        chk("R8 R9 last segment after wrap", dw0(0), 32'h1000_0024);
        chk_buf("R8 data seg1", 32'h302, 0, 64, 8'h40);
        chk_buf("R9 data seg2", 32'h182, 64, 36, 8'h40);
        chk("R12 one pulse per frame", n_done - d, 1);
    endtask

    task automatic t_no_buf;
        int nb, lo, w;
        nb = n_nobuf; lo = n_lost; w = n_wr;
        send(20, 8'h60, 5'd0, 1'b0, 1'b0);
        chk("R3 no-buffer pulse", n_nobuf - nb, 1);
        chk("R3 lost pulse", n_lost - lo, 1);
        chk("R3 no writes", n_wr - w, 0);
        chk("R3 d1 untouched", dw0(1), 32'h3012_0040);
    endtask

    task automatic t_align;
        int nb, lo;
        nb = n_nobuf; lo = n_lost;
        set_desc(1, 128, 32'h200, 1'b0);
        send(70, 8'h70, 5'd0, 1'b0, 1'b0);
        chk("R4 lost only", n_lost - lo, 1);
        chk("R4 no no-buffer", n_nobuf - nb, 0);
        chk("R4 d1 untouched", dw0(1), 32'h8000_0000);
        mem[((BASE + 16) >> 2) + 2] = 32'h202;
        send(64, 8'h11, 5'd0, 1'b0, 1'b0);
        chk("R4 d1 still current", dw0(1), 32'h3000_0040);
        chk_buf("R4 data", 32'h202, 0, 64, 8'h11);
    endtask

    task automatic t_long;
        for (int w = 256; w < 768; w++) mem[w] = '0;
        set_desc(2, 1600, 32'h402, 1'b0);
        send(1530, 8'h05, 5'd0, 1'b0, 1'b0);
        chk("R11 truncated status", dw0(2), 32'h3004_05EE);
        chk_buf("R11 truncated data", 32'h402, 0, 1518, 8'h05);
        chk("R11 byte past limit", rd_byte(32'h402 + 1518), 0);
        keep_long = 1'b1;
        set_desc(3, 1600, 32'h402, 1'b1);
        send(1530, 8'h09, 5'd0, 1'b0, 1'b0);
        keep_long = 1'b0;
        chk("R11 whole status", dw0(3), 32'h3000_05FA);
        chk_buf("R11 whole data", 32'h402, 0, 1530, 8'h09);
    endtask

    initial begin
        for (int w = 0; w < 1024; w++) mem[w] = '0;
        set_desc(0, 128, 32'h182, 1'b0);
        set_desc(1, 128, 32'h202, 1'b0);
        set_desc(2, 128, 32'h282, 1'b0);
        set_desc(3, 128, 32'h302, 1'b1);
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_disabled;
        t_error_flags;
        t_runt;
        t_multi_wrap;
        t_no_buf;
        t_align;
        t_long;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule